// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the bit-level clock for an I2C master. A packed 32-bit timing word sets one prescaled time unit and four intervals built on it: how long SCL is held low, how long it is left high, how long SDA is held after SCL falls, and how long SDA must be settled before SCL rises. The block drives the SCL and SDA lines through open-drain pull-down enables. It gives a byte engine two one-cycle strobes: one marks when SDA takes the next transmit bit, and one marks when the received bit may be read from the filtered SDA level.

Both bus inputs pass through a two-flop synchroniser and then a digital glitch filter. The filter length is programmable from 0 to 16 clocks. The controller measures each SCL phase from the moment its own filtered copy of SCL shows the new level. A slave that holds SCL low therefore lengthens the high phase, and the block flags this as clock stretching. The controller is a five-state machine:
- IDLE: lines released.
- SYNC_LOW: SCL is driven low and the block waits to see it low.
- LOW_COUNT: the low interval is counted and the SDA change point is placed.
- SYNC_HIGH: SCL is released and the block waits to see it high; stretching is detected here.
- HIGH_COUNT: the high interval is counted and the sample point is placed.

Transitions:
- start: IDLE to SYNC_LOW, on enable and run.
- low_seen: SYNC_LOW to LOW_COUNT.
- low_done: LOW_COUNT to SYNC_HIGH.
- high_seen: SYNC_HIGH to HIGH_COUNT.
- next_bit: HIGH_COUNT to SYNC_LOW, when run is still high.
- finish: HIGH_COUNT to IDLE, when run is low.
- abort: any state to IDLE, when enable is low.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is held and after it, scl_oe, sda_oe, sda_chg, sda_smp and stretch are 0, and scl_filt and sda_filt are 1.
- R2: The timing word is captured on cfg_wr only while enable is 0; a write while enable is 1 changes no timing. The fields are: prescaler PS at bits 31:28, setup count SU at 23:20, hold count HD at 19:16, high count HI at 15:8, low count LO at 7:0. Bits 27:24 are ignored.
- R3: With U = PS+1 and filter length N, every SCL pull-down interval lasts 3+N+max((LO+1)·U, HD·U+1+(SU+1)·U) clocks.
- R4: Without stretching, every SCL released interval between two pull-downs lasts 3+N+(HI+1)·U clocks.
- R5: sda_chg is a one-cycle pulse 3+N+HD·U cycles after scl_oe rises (counting from 0). At the next edge sda_oe becomes the inverse of tx_bit, and sda_oe changes at no other time while enable is 1.
- R6: Without stretching, sda_smp is a one-cycle pulse 3+N cycles after scl_oe falls, and only while SCL is released and seen high.
- R7: The high count starts only once filtered SCL is high. stretch is 1 while SCL has been released for at least 3+N cycles and is not yet seen high. sda_smp follows 3+N cycles after the slave lets go, and stretch never rises without stretching.
- R8: A level change on a bus input reaches the filtered output 2+N clocks later when it lasts at least N clocks. A change shorter than N clocks (N ≥ 1) never appears on the output.
- R9: With enable 1, raising run pulls SCL low one cycle later. With run low at the end of a high interval, the block returns to idle and SCL stays released.
- R10: One cycle after enable goes low, scl_oe, sda_oe and stretch are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; timing writes are accepted only while low |
| run | input | 1 | Keep generating SCL periods while high |
| cfg_wr | input | 1 | Write strobe for the timing word |
| cfg_word | input | 32 | Packed timing word |
| filt_len | input | 5 | Glitch filter length in clocks, 0 to 16 (0 bypasses) |
| tx_bit | input | 1 | Next bit to place on SDA |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_chg | output | 1 | Strobe: SDA takes tx_bit at this edge |
| sda_smp | output | 1 | Strobe: sample sda_filt now |
| stretch | output | 1 | A slave is holding SCL low |
| scl_filt | output | 1 | Synchronised, filtered SCL |
| sda_filt | output | 1 | Synchronised, filtered SDA |

## Verification
Five timing words are applied, chosen so that their outcomes cannot be confused:
- One is the all-zero minimum.
- In one the low count sets the low phase.
- In one the hold-plus-setup path lengthens the low phase.
- One uses the largest filter length.
- One uses the largest prescaler.

Each run measures the length of both phases and the exact positions of the change and sample strobes. A prescaler or field-position fault therefore moves several measured numbers at once. Directed cases then cover the remaining behaviour:
- A slave holds SCL low to stretch the high phase.
- A write arrives while the block is enabled.
- SDA glitches slightly shorter than the filter length.
- enable is dropped in mid-phase.
- run is dropped.

// File: rtl/i2c_tmg_pkg.sv
`timescale 1ns/1ps
package i2c_tmg_pkg;
    localparam int WORD_W    = 32;
    localparam int PRESC_W   = 4;
    localparam int DLY_W     = 4;
    localparam int PHASE_W   = 8;
    localparam int FLT_W     = 5;
    localparam int FLT_MAX   = 16;
    localparam int SYNC_FIX  = 3;

    localparam int PRESC_LSB = 28;
    localparam int SETUP_LSB = 20;
    localparam int HOLD_LSB  = 16;
    localparam int HIGH_LSB  = 8;
    localparam int LOW_LSB   = 0;

    localparam int CNT_W = ((PHASE_W > DLY_W + 1) ? PHASE_W : DLY_W + 1) + PRESC_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC_LOW,
        ST_LOW_COUNT,
        ST_SYNC_HIGH,
        ST_HIGH_COUNT
    } scl_state_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [DLY_W-1:0]   setup;
        logic [DLY_W-1:0]   hold;
        logic [PHASE_W-1:0] high;
        logic [PHASE_W-1:0] low;
    } tmg_cfg_t;

    function automatic tmg_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        tmg_cfg_t c;
        c.presc = w[PRESC_LSB +: PRESC_W];
        c.setup = w[SETUP_LSB +: DLY_W];
        c.hold  = w[HOLD_LSB  +: DLY_W];
        c.high  = w[HIGH_LSB  +: PHASE_W];
        c.low   = w[LOW_LSB   +: PHASE_W];
        return c;
    endfunction
endpackage

// File: rtl/i2c_glitch_filter.sv
`timescale 1ns/1ps
module i2c_glitch_filter
    import i2c_tmg_pkg::*;
#(
    parameter int LEN_W = FLT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic [LEN_W-1:0] flt_len,
    output logic             level
);
    logic             sync1, sync2, held;
    logic [LEN_W-1:0] run_cnt;
    logic             long_enough;

    assign long_enough = ({1'b0, run_cnt} + (LEN_W+1)'(1)) >= {1'b0, flt_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1   <= 1'b1;
            sync2   <= 1'b1;
            held    <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            if (sync2 == held) begin
                run_cnt <= '0;
            end else if (long_enough) begin
                held    <= sync2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + LEN_W'(1);
            end
        end
    end

    assign level = (flt_len == '0) ? sync2 : held;
endmodule

// File: rtl/i2c_tmg_decode.sv
`timescale 1ns/1ps
module i2c_tmg_decode
    import i2c_tmg_pkg::*;
#(
    parameter int LEN_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_word,
    output logic [LEN_W-1:0]  low_len,
    output logic [LEN_W-1:0]  high_len,
    output logic [LEN_W-1:0]  hold_pt
);
    tmg_cfg_t         cfg_q;
    logic [LEN_W-1:0] unit, low_by_count, low_by_data, high_c, hold_c, low_c;
    logic             rsvd_unused;

    assign rsvd_unused = ^cfg_word[SETUP_LSB+DLY_W +: PRESC_LSB-SETUP_LSB-DLY_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr && !enable) begin
            cfg_q <= unpack_cfg(cfg_word);
        end
    end

    always_comb begin
        unit         = LEN_W'(cfg_q.presc) + LEN_W'(1);
        low_by_count = (LEN_W'(cfg_q.low) + LEN_W'(1)) * unit;
        hold_c       = LEN_W'(cfg_q.hold) * unit;
        low_by_data  = hold_c + LEN_W'(1) + (LEN_W'(cfg_q.setup) + LEN_W'(1)) * unit;
        low_c        = (low_by_data > low_by_count) ? low_by_data : low_by_count;
        high_c       = (LEN_W'(cfg_q.high) + LEN_W'(1)) * unit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len  <= LEN_W'(2);
            high_len <= LEN_W'(1);
            hold_pt  <= '0;
        end else begin
            low_len  <= low_c;
            high_len <= high_c;
            hold_pt  <= hold_c;
        end
    end
endmodule

// File: rtl/i2c_scl_fsm.sv
`timescale 1ns/1ps
module i2c_scl_fsm
    import i2c_tmg_pkg::*;
#(
    parameter int LEN_W  = CNT_W,
    parameter int SYNC_W = FLT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              run,
    input  logic              tx_bit,
    input  logic              scl_level,
    input  logic [LEN_W-1:0]  low_len,
    input  logic [LEN_W-1:0]  high_len,
    input  logic [LEN_W-1:0]  hold_pt,
    input  logic [SYNC_W-1:0] sync_len,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              sda_chg,
    output logic              sda_smp,
    output logic              stretch
);
    scl_state_e       state, nxt;
    logic [LEN_W-1:0] cyc;

    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       if (run) nxt = ST_SYNC_LOW;
                ST_SYNC_LOW:   if (!scl_level) nxt = ST_LOW_COUNT;
                ST_LOW_COUNT:  if (cyc == low_len - LEN_W'(1)) nxt = ST_SYNC_HIGH;
                ST_SYNC_HIGH:  if (scl_level) nxt = ST_HIGH_COUNT;
                ST_HIGH_COUNT: if (cyc == high_len - LEN_W'(1))
                                   nxt = run ? ST_SYNC_LOW : ST_IDLE;
                default:       nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc <= '0;
        else if (nxt != state)   cyc <= '0;
        else if (cyc != '1)      cyc <= cyc + LEN_W'(1);
    end

    always_comb begin
        scl_oe  = 1'b0;
        sda_chg = 1'b0;
        sda_smp = 1'b0;
        stretch = 1'b0;
        unique case (state)
            ST_IDLE:       ;
            ST_SYNC_LOW:   scl_oe = 1'b1;
            ST_LOW_COUNT:  begin
                scl_oe  = 1'b1;
                sda_chg = (cyc == hold_pt);
            end
            ST_SYNC_HIGH:  stretch = (cyc >= LEN_W'(sync_len));
            ST_HIGH_COUNT: sda_smp = (cyc == '0);
            default:       ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sda_oe <= 1'b0;
        else if (!enable) sda_oe <= 1'b0;
        else if (sda_chg) sda_oe <= ~tx_bit;
    end
endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer
    import i2c_tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              run,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [FLT_W-1:0]  filt_len,
    input  logic              tx_bit,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              sda_chg,
    output logic              sda_smp,
    output logic              stretch,
    output logic              scl_filt,
    output logic              sda_filt
);
    localparam int LINES  = 2;
    localparam int SYNC_W = FLT_W + 1;

    logic [FLT_W-1:0]  flt_eff;
    logic [SYNC_W-1:0] sync_len;
    logic [LINES-1:0]  pins, levels;
    logic [CNT_W-1:0]  low_len, high_len, hold_pt;

    assign flt_eff  = (filt_len > FLT_W'(FLT_MAX)) ? FLT_W'(FLT_MAX) : filt_len;
    assign sync_len = SYNC_W'(flt_eff) + SYNC_W'(SYNC_FIX);
    assign pins     = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        i2c_glitch_filter #(.LEN_W(FLT_W)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pins[g]),
            .flt_len (flt_eff),
            .level   (levels[g])
        );
    end

    assign scl_filt = levels[0];
    assign sda_filt = levels[1];

    i2c_tmg_decode #(.LEN_W(CNT_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cfg_wr   (cfg_wr),
        .cfg_word (cfg_word),
        .low_len  (low_len),
        .high_len (high_len),
        .hold_pt  (hold_pt)
    );

    i2c_scl_fsm #(.LEN_W(CNT_W), .SYNC_W(SYNC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .run       (run),
        .tx_bit    (tx_bit),
        .scl_level (scl_filt),
        .low_len   (low_len),
        .high_len  (high_len),
        .hold_pt   (hold_pt),
        .sync_len  (sync_len),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .sda_chg   (sda_chg),
        .sda_smp   (sda_smp),
        .stretch   (stretch)
    );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
`timescale 1ns/1ps
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tx_bit,
    input logic scl_oe,
    input logic sda_oe,
    input logic sda_chg,
    input logic sda_smp,
    input logic stretch,
    input logic scl_filt
);
    AST_CHG_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg |-> scl_oe); // R5
    AST_SDA_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_chg && enable) |=> (sda_oe == !$past(tx_bit))); // R5
    AST_SDA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sda_chg) |=> $stable(sda_oe)); // R5
    AST_SMP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sda_smp |-> (!scl_oe && scl_filt)); // R6
    AST_STRETCH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |-> (!scl_oe && !sda_smp)); // R7
    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_oe && !sda_oe && !stretch)); // R10
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tx_bit   (tx_bit),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .sda_chg  (sda_chg),
    .sda_smp  (sda_smp),
    .stretch  (stretch),
    .scl_filt (scl_filt)
);

// File: tb/i2c_scl_timer_test.sv
`timescale 1ns/1ps
module i2c_scl_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, run = 1'b0, cfg_wr = 1'b0, tx_bit = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [4:0]  filt_len = '0;
    logic        slave_hold = 1'b0, sda_pull = 1'b0;
    logic        scl_in, sda_in;
    logic        scl_oe, sda_oe, sda_chg, sda_smp, stretch, scl_filt, sda_filt;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign scl_in = ~scl_oe & ~slave_hold;
    assign sda_in = ~sda_oe & ~sda_pull;

    i2c_scl_timer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .cfg_wr(cfg_wr),
        .cfg_word(cfg_word), .filt_len(filt_len), .tx_bit(tx_bit),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_chg(sda_chg), .sda_smp(sda_smp), .stretch(stretch),
        .scl_filt(scl_filt), .sda_filt(sda_filt)
    );

    // Vectors: prescaler, setup, hold, high, low, filter; expected low length,
    // high length and change-strobe offset (from R3, R4, R5).
    localparam int VN = 5;
    localparam int V_PS [VN] = '{0, 1, 3, 0, 15};
    localparam int V_SU [VN] = '{0, 2, 4, 1, 0};
    localparam int V_HD [VN] = '{0, 1, 5, 7, 2};
    localparam int V_HI [VN] = '{3, 5, 2, 0, 9};
    localparam int V_LO [VN] = '{4, 6, 2, 0, 19};
    localparam int V_N  [VN] = '{0, 2, 1, 16, 3};
    localparam int E_LO [VN] = '{8, 19, 45, 29, 326};
    localparam int E_HI [VN] = '{7, 17, 16, 20, 166};
    localparam int E_CH [VN] = '{3, 7, 24, 26, 38};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic wait_scl(input logic want);
        int guard = 0;
        while (scl_oe !== want && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic load_cfg(input int i);
        @(negedge clk);
        enable = 1'b0; run = 1'b0;
        repeat (2) @(negedge clk);
        cfg_word = {4'(V_PS[i]), 4'h0, 4'(V_SU[i]), 4'(V_HD[i]), 8'(V_HI[i]), 8'(V_LO[i])};
        filt_len = 5'(V_N[i]);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic measure_low(output int len, output int chg_at, output int sda_end);
        len = 0; chg_at = -1;
        while (scl_oe === 1'b1 && len < 20000) begin
            if (sda_chg) chg_at = len;
            len++;
            @(negedge clk);
        end
        sda_end = int'(sda_oe);
    endtask

    task automatic measure_high(output int len, output int smp_at, output int str_cnt);
        len = 0; smp_at = -1; str_cnt = 0;
        while (scl_oe === 1'b0 && len < 20000) begin
            if (sda_smp) smp_at = len;
            if (stretch) str_cnt++;
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int lo, hi, ch, sd, sm, st, rises, lows, k;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 scl_oe in reset", int'(scl_oe), 0);
        chk("R1 sda_oe in reset", int'(sda_oe), 0);
        chk("R1 strobes in reset", int'(sda_chg | sda_smp), 0);
        chk("R1 stretch in reset", int'(stretch), 0);
        chk("R1 filtered levels in reset", int'(scl_filt & sda_filt), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 scl_oe after reset", int'(scl_oe), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < VN; i++) begin
            load_cfg(i);
            tx_bit = i[0];
            enable = 1'b1; run = 1'b1;
            @(negedge clk);
            chk($sformatf("R9 start pulls SCL low v%0d", i), int'(scl_oe), 1);
            wait_scl(1'b1);
            measure_low(lo, ch, sd);
            chk($sformatf("R3 R2 low length v%0d", i), lo, E_LO[i]);
            chk($sformatf("R5 change offset v%0d", i), ch, E_CH[i]);
            chk($sformatf("R5 sda_oe value v%0d", i), sd, i[0] ? 0 : 1);
            measure_high(hi, sm, st);
            chk($sformatf("R4 high length v%0d", i), hi, E_HI[i]);
            chk($sformatf("R6 sample offset v%0d", i), sm, 3 + V_N[i]);
            chk($sformatf("R7 no stretch flag v%0d", i), st, 0);
            run = 1'b0;
            wait_scl(1'b0);
            rises = 0;
            for (int c = 0; c < E_HI[i] + 40; c++) begin
                @(negedge clk);
                if (scl_oe) rises++;
            end
            chk($sformatf("R9 idle after run drop v%0d", i), rises, 0);
        end

        // R2: write while enabled is ignored
        load_cfg(0);
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        wait_scl(1'b1);
        cfg_word = {4'd15, 4'h0, 4'd0, 4'd2, 8'd9, 8'd19};
        filt_len = 5'd0;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        wait_scl(1'b0);
        wait_scl(1'b1);
        measure_low(lo, ch, sd);
        chk("R2 write while enabled ignored (low)", lo, E_LO[0]);
        measure_high(hi, sm, st);
        chk("R2 write while enabled ignored (high)", hi, E_HI[0]);

        // R10: enable drop mid-phase
        tx_bit = 1'b0;
        wait_scl(1'b1);
        repeat (4) @(negedge clk);
        chk("R10 sda_oe set before disable", int'(sda_oe), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R10 scl_oe released", int'(scl_oe), 0);
        chk("R10 sda_oe released", int'(sda_oe), 0);

        // R7: clock stretching
        load_cfg(0);
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        wait_scl(1'b1);
        slave_hold = 1'b1;
        wait_scl(1'b0);
        sm = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (sda_smp) sm++;
        end
        chk("R7 no sample while held low", sm, 0);
        chk("R7 stretch flag raised", int'(stretch), 1);
        slave_hold = 1'b0;
        k = 0;
        while (!sda_smp && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk("R7 sample after slave release", k, 3);
        chk("R7 stretch cleared", int'(stretch), 0);
        run = 1'b0;
        wait_scl(1'b0);
        repeat (20) @(negedge clk);
        enable = 1'b0;

        // R8: glitch filter on SDA
        filt_len = 5'd4;
        repeat (10) @(negedge clk);
        lows = 0;
        sda_pull = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (!sda_filt) lows++;
        end
        sda_pull = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (!sda_filt) lows++;
        end
        chk("R8 short glitch removed", lows, 0);
        sda_pull = 1'b1;
        k = 0;
        while (sda_filt && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk("R8 latency N=4", k, 6);
        sda_pull = 1'b0;
        repeat (12) @(negedge clk);
        filt_len = 5'd0;
        repeat (4) @(negedge clk);
        sda_pull = 1'b1;
        k = 0;
        while (sda_filt && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk("R8 latency N=0", k, 2);
        sda_pull = 1'b0;
        repeat (5) @(negedge clk);

        finish_run();
    end
endmodule